// File: doc/BRIEF.md
# Dual Byte-Stack Operand Unit

The unit holds the two byte stacks of an 8-bit stack-machine core: stack 0 for data, stack 1 for return addresses. The core sends one request per instruction. A request gives the number of operands to take from the source stack and the number of results to write back. It also carries three mode flags. `keep_i` leaves the operands in place. `ret_i` swaps which stack acts as source and destination. `short_i` makes every operand and result a 16-bit word built from two stack bytes. A transfer request moves one operand from the source stack onto the opposite stack.

Each request completes atomically. The unit registers the request and raises `done_o` for one cycle on the next clock. In that same cycle it presents the operands as they were before the update, together with the new stack depths. If the source stack holds too few bytes, the request aborts and sets a sticky underflow flag. If the destination stack would grow past its capacity, the request aborts and sets a sticky overflow flag. An aborted request changes neither stack. Peek is a keep request with no results, so a core that needs operands before it can compute its results issues a peek first and then the real request.

Top module: `dbs_unit`

## Requirements
- R1: After reset both depths are 0, both fault flags are 0 and `done_o` is 0.
- R2: Every cycle with `req_valid_i` high yields a single-cycle `done_o` on the next cycle. A new request may follow every cycle, and each request sees the stacks as updated by the request before it.
- R3: In byte mode, operand k (k = 0 is the top) is the k-th byte below the top of the source stack, zero-extended to 16 bits on `opnd<k>_o`. Without keep, `pop_cnt_i` bytes are removed.
- R4: In short mode, operand k equals {byte at depth 2k+1, byte at depth 2k}, so the top byte is the low half. A result is pushed high byte first and then low byte. Result 0 goes in before result 1.
- R5: With `ret_i` = 0 the source and destination are stack 0. With `ret_i` = 1 both are stack 1.
- R6: With `keep_i` = 1 the source depth is not reduced by the operands, and results land above the untouched operands.
- R7: With `xfer_i` = 1, one operand (of the width set by `short_i`) is taken from the source stack and pushed onto the opposite stack. `pop_cnt_i`, `push_cnt_i`, `res0_i` and `res1_i` are ignored for such a request.
- R8: If the source depth is below the bytes needed, `unf_o` is set and stays set until reset, and neither stack changes.
- R9: If the destination depth after pops plus the result bytes would exceed DEPTH (256), `ovf_o` is set and stays set, and neither stack changes. Filling to exactly DEPTH is legal. Underflow takes precedence: a request that underflows never sets `ovf_o`.
- R10: Neither depth ever exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request strobe, one per cycle |
| pop_cnt_i | input | 2 | operand count, 0..3 |
| push_cnt_i | input | 2 | result count, 0..2 |
| xfer_i | input | 1 | move one operand to the opposite stack |
| keep_i | input | 1 | read operands without removing them |
| ret_i | input | 1 | use stack 1 in place of stack 0 |
| short_i | input | 1 | operands and results are 16-bit |
| res0_i | input | 16 | result 0, pushed first |
| res1_i | input | 16 | result 1 |
| done_o | output | 1 | request completed |
| opnd0_o | output | 16 | operand 0 (top) |
| opnd1_o | output | 16 | operand 1 |
| opnd2_o | output | 16 | operand 2 |
| dcnt_o | output | 9 | data stack depth in bytes |
| rcnt_o | output | 9 | return stack depth in bytes |
| unf_o | output | 1 | sticky underflow |
| ovf_o | output | 1 | sticky overflow |

## Verification
Two things can fall in the same clock edge: a pop from one stack and a push onto the other. A transfer does exactly that, and a return-flag transfer does it in the reverse direction. The bench issues such transfers back to back with plain pushes and pops, so each request also relies on the pointer the previous edge wrote. A scoreboard with its own byte model predicts the operands, both depths and the flags, and compares them whenever `done_o` appears. Fault precedence is provoked with a request that underflows an empty data stack while it would also overflow a full return stack, and the bench judges it by `ovf_o` staying low.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned MAX_OPND = 3;
  localparam int unsigned MAX_RES  = 2;
  localparam int unsigned RD_BYTES = 2 * MAX_OPND;
  localparam int unsigned WR_BYTES = 2 * MAX_RES;
  localparam int unsigned NW       = $clog2(WR_BYTES + 1);
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;
endpackage

// File: rtl/dbs_stack.sv
module dbs_stack
  import dbs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        upd_i,
  input  logic [CW-1:0]               cnt_d_i,
  input  logic [CW-1:0]               wr_base_i,
  input  logic [NW-1:0]               wr_n_i,
  input  logic [WR_BYTES-1:0][7:0]    wr_byte_i,
  output logic [CW-1:0]               cnt_o,
  output logic [RD_BYTES-1:0][7:0]    rd_byte_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  byte_t mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [WR_BYTES-1:0][AW-1:0] wr_idx;

  always_comb begin
    for (int j = 0; j < WR_BYTES; j++) begin
      logic [CW-1:0] t;
      t = wr_base_i + CW'(j);
      wr_idx[j] = t[AW-1:0];
    end
    for (int j = 0; j < RD_BYTES; j++) begin
      logic [CW-1:0] t;
      t = cnt_q - CW'(j + 1);
      rd_byte_o[j] = mem_q[t[AW-1:0]];
    end
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < WR_BYTES; j++)
      if (upd_i && (NW'(j) < wr_n_i)) mem_q[wr_idx[j]] <= wr_byte_i[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (upd_i) cnt_q <= cnt_d_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                            req_valid_i,
  input  logic [1:0]                      pop_cnt_i,
  input  logic [1:0]                      push_cnt_i,
  input  logic                            xfer_i,
  input  logic                            keep_i,
  input  logic                            ret_i,
  input  logic                            short_i,
  input  word_t                           res0_i,
  input  word_t                           res1_i,
  input  logic [1:0][CW-1:0]              cnt_i,
  input  logic [1:0][RD_BYTES-1:0][7:0]   rd_i,
  output logic [1:0]                      upd_o,
  output logic [1:0][CW-1:0]              cnt_d_o,
  output logic [CW-1:0]                   wr_base_o,
  output logic [1:0][NW-1:0]              wr_n_o,
  output logic [WR_BYTES-1:0][7:0]        wr_byte_o,
  output logic [MAX_OPND-1:0][15:0]       opnd_o,
  output logic                            unf_o,
  output logic                            ovf_o
);
  localparam int unsigned XW = CW + 2;

  logic src, dst, ok;
  logic [1:0] npop, npush;
  logic [XW-1:0] pop_b, push_b, src_c, dst_c, src_after, dst_base, dst_top;
  logic [RD_BYTES-1:0][7:0] srd;
  word_t r0;

  always_comb begin
    src   = ret_i;
    dst   = xfer_i ? ~ret_i : ret_i;
    npop  = xfer_i ? 2'd1 : pop_cnt_i;
    npush = xfer_i ? 2'd1 : ((push_cnt_i > 2'd2) ? 2'd2 : push_cnt_i);
    pop_b  = short_i ? XW'({npop, 1'b0})  : XW'(npop);
    push_b = short_i ? XW'({npush, 1'b0}) : XW'(npush);
    src_c = XW'(cnt_i[src]);
    dst_c = XW'(cnt_i[dst]);
    srd   = rd_i[src];

    for (int k = 0; k < MAX_OPND; k++)
      opnd_o[k] = short_i ? {srd[2*k+1], srd[2*k]} : {8'h00, srd[k]};

    src_after = keep_i ? src_c : src_c - pop_b;
    dst_base  = (dst == src) ? src_after : dst_c;
    dst_top   = dst_base + push_b;
    unf_o = req_valid_i && (src_c < pop_b);
    ovf_o = req_valid_i && !unf_o && (dst_top > XW'(DEPTH));
    ok    = req_valid_i && !unf_o && !ovf_o;

    r0 = xfer_i ? opnd_o[0] : res0_i;
    if (short_i) wr_byte_o = {res1_i[7:0], res1_i[15:8], r0[7:0], r0[15:8]};
    else         wr_byte_o = {8'h00, 8'h00, res1_i[7:0], r0[7:0]};
    wr_base_o = dst_base[CW-1:0];

    for (int s = 0; s < 2; s++) begin
      upd_o[s]   = ok;
      wr_n_o[s]  = (s == int'(dst)) ? NW'(push_b) : '0;
      if (s == int'(dst))      cnt_d_o[s] = dst_top[CW-1:0];
      else if (s == int'(src)) cnt_d_o[s] = src_after[CW-1:0];
      else                     cnt_d_o[s] = cnt_i[s];
    end
  end
endmodule

// File: rtl/dbs_unit.sv
module dbs_unit
  import dbs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    pop_cnt_i,
  input  logic [1:0]    push_cnt_i,
  input  logic          xfer_i,
  input  logic          keep_i,
  input  logic          ret_i,
  input  logic          short_i,
  input  logic [15:0]   res0_i,
  input  logic [15:0]   res1_i,
  output logic          done_o,
  output logic [15:0]   opnd0_o,
  output logic [15:0]   opnd1_o,
  output logic [15:0]   opnd2_o,
  output logic [CW-1:0] dcnt_o,
  output logic [CW-1:0] rcnt_o,
  output logic          unf_o,
  output logic          ovf_o
);
  logic [1:0]                    upd_w;
  logic [1:0][CW-1:0]            cnt_w, cnt_d_w;
  logic [1:0][NW-1:0]            wr_n_w;
  logic [1:0][RD_BYTES-1:0][7:0] rd_w;
  logic [CW-1:0]                 wr_base_w;
  logic [WR_BYTES-1:0][7:0]      wr_byte_w;
  logic [MAX_OPND-1:0][15:0]     opnd_w, opnd_q;
  logic                          unf_hit, ovf_hit, done_q, unf_q, ovf_q;

  dbs_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
    .req_valid_i, .pop_cnt_i, .push_cnt_i, .xfer_i, .keep_i, .ret_i, .short_i,
    .res0_i, .res1_i,
    .cnt_i(cnt_w), .rd_i(rd_w), .upd_o(upd_w), .cnt_d_o(cnt_d_w),
    .wr_base_o(wr_base_w), .wr_n_o(wr_n_w), .wr_byte_o(wr_byte_w),
    .opnd_o(opnd_w), .unf_o(unf_hit), .ovf_o(ovf_hit)
  );

  for (genvar s = 0; s < 2; s++) begin : g_stk
    dbs_stack #(.DEPTH(DEPTH), .CW(CW)) i_stk (
      .clk_i, .rst_ni,
      .upd_i(upd_w[s]), .cnt_d_i(cnt_d_w[s]), .wr_base_i(wr_base_w),
      .wr_n_i(wr_n_w[s]), .wr_byte_i(wr_byte_w),
      .cnt_o(cnt_w[s]), .rd_byte_o(rd_w[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      opnd_q <= '0;
      unf_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= req_valid_i;
      if (req_valid_i) opnd_q <= opnd_w;
      unf_q <= unf_q | unf_hit;
      ovf_q <= ovf_q | ovf_hit;
    end
  end

  assign done_o  = done_q;
  assign opnd0_o = opnd_q[0];
  assign opnd1_o = opnd_q[1];
  assign opnd2_o = opnd_q[2];
  assign dcnt_o  = cnt_w[0];
  assign rcnt_o  = cnt_w[1];
  assign unf_o   = unf_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dbs_unit_chk.sv
module dbs_unit_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    pop_cnt_i,
  input logic [1:0]    push_cnt_i,
  input logic          xfer_i,
  input logic          keep_i,
  input logic          ret_i,
  input logic          short_i,
  input logic [15:0]   res0_i,
  input logic [15:0]   res1_i,
  input logic          done_o,
  input logic [15:0]   opnd0_o,
  input logic [15:0]   opnd1_o,
  input logic [15:0]   opnd2_o,
  input logic [CW-1:0] dcnt_o,
  input logic [CW-1:0] rcnt_o,
  input logic          unf_o,
  input logic          ovf_o
);
  // R2
  done_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  // R2
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  // R8
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  // R8
  unf_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> ($stable(dcnt_o) && $stable(rcnt_o)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R9
  ovf_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($stable(dcnt_o) && $stable(rcnt_o)));
  // R9
  unf_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> !$rose(ovf_o));
  // R6
  peek_keeps_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && keep_i && !xfer_i && push_cnt_i == 2'd0)
      |=> ($stable(dcnt_o) && $stable(rcnt_o)));
  // R7
  xfer_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && xfer_i && !keep_i)
      |=> ({1'b0, dcnt_o} + {1'b0, rcnt_o} == $past({1'b0, dcnt_o} + {1'b0, rcnt_o})));
  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcnt_o <= CW'(DEPTH)) && (rcnt_o <= CW'(DEPTH)));
endmodule

bind dbs_unit dbs_unit_chk #(.DEPTH(DEPTH), .CW(CW)) i_dbs_unit_chk (.*);

// File: tb/test_dbs_unit.sv
module test_dbs_unit;
  localparam int DEPTH = 256;
  localparam int CW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, xfer = 0, keep = 0, ret = 0, short_m = 0;
  logic [1:0] pop_cnt = 0, push_cnt = 0;
  logic [15:0] res0 = 0, res1 = 0;
  logic done;
  logic [15:0] op0, op1, op2;
  logic [CW-1:0] dcnt, rcnt;
  logic unf, ovf;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct {
    logic [15:0] op [3];
    int nop;
    int dc, rc;
    bit uf, of;
    string tag;
  } exp_t;
  exp_t sb [$];

  byte unsigned mdl [2][DEPTH];
  int mcnt [2];
  bit muf, mof;

  always #10 clk = ~clk;

  dbs_unit #(.DEPTH(DEPTH)) i_dbs_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .pop_cnt_i(pop_cnt),
    .push_cnt_i(push_cnt), .xfer_i(xfer), .keep_i(keep), .ret_i(ret),
    .short_i(short_m), .res0_i(res0), .res1_i(res1), .done_o(done),
    .opnd0_o(op0), .opnd1_o(op1), .opnd2_o(op2), .dcnt_o(dcnt), .rcnt_o(rcnt),
    .unf_o(unf), .ovf_o(ovf)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic byte unsigned peek_b(int s, int j);
    return mdl[s][(mcnt[s] - 1 - j) & (DEPTH - 1)];
  endfunction

  // driver: predicts from the requirements and queues the expectation
  task automatic issue(int np, int nr, bit k, bit r, bit s, bit x,
                       logic [15:0] a0, logic [15:0] a1, string tag);
    exp_t e;
    int src, dst, pb, qb, sa, db, ne, nre;
    byte unsigned wb [4];
    @(negedge clk);
    req_valid = 1; pop_cnt = 2'(np); push_cnt = 2'(nr); keep = k; ret = r;
    short_m = s; xfer = x; res0 = a0; res1 = a1;
    src = r; dst = x ? 1 - r : r;
    ne = x ? 1 : np; nre = x ? 1 : nr;
    pb = s ? 2 * ne : ne; qb = s ? 2 * nre : nre;
    for (int i = 0; i < 3; i++)
      e.op[i] = s ? {peek_b(src, 2*i+1), peek_b(src, 2*i)} : {8'h00, peek_b(src, i)};
    sa = k ? mcnt[src] : mcnt[src] - pb;
    db = (dst == src) ? sa : mcnt[dst];
    e.nop = (mcnt[src] < pb) ? 0 : ne;
    if (mcnt[src] < pb) muf = 1;
    else if (db + qb > DEPTH) mof = 1;
    else begin
      logic [15:0] v0;
      v0 = x ? e.op[0] : a0;
      if (s) begin wb[0] = v0[15:8]; wb[1] = v0[7:0]; wb[2] = a1[15:8]; wb[3] = a1[7:0]; end
      else   begin wb[0] = v0[7:0];  wb[1] = a1[7:0]; wb[2] = 0; wb[3] = 0; end
      mcnt[src] = sa;
      for (int i = 0; i < qb; i++) mdl[dst][db + i] = wb[i];
      mcnt[dst] = db + qb;
    end
    e.dc = mcnt[0]; e.rc = mcnt[1]; e.uf = muf; e.of = mof; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 0; rst_n = 0;
    mcnt[0] = 0; mcnt[1] = 0; muf = 0; mof = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (done) begin
        if (sb.size() == 0) chk(0, "R2 done without request", 1, 0);
        else begin
          exp_t e;
          logic [15:0] got [3];
          e = sb.pop_front();
          got[0] = op0; got[1] = op1; got[2] = op2;
          for (int i = 0; i < e.nop; i++)
            chk(got[i] === e.op[i], $sformatf("%s operand%0d", e.tag, i), got[i], e.op[i]);
          chk(dcnt === CW'(e.dc), {e.tag, " data depth"}, dcnt, e.dc);
          chk(rcnt === CW'(e.rc), {e.tag, " return depth"}, rcnt, e.rc);
          chk(unf === e.uf, {e.tag, " unf"}, unf, e.uf);
          chk(ovf === e.of, {e.tag, " ovf"}, ovf, e.of);
        end
      end
    end
  end

  initial begin
    repeat (4_000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mcnt[0] = 0; mcnt[1] = 0; muf = 0; mof = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(dcnt == 0 && rcnt == 0, "R1 depths after reset", {dcnt, rcnt}, 0);
    chk(!unf && !ovf && !done, "R1 flags after reset", {unf, ovf, done}, 0);

    // R3 byte pushes and pops, back to back (R2)
    issue(0, 2, 0, 0, 0, 0, 16'h0011, 16'h0022, "R3 push bytes");
    issue(2, 0, 1, 0, 0, 0, 0, 0, "R6 peek two bytes");
    issue(2, 1, 0, 0, 0, 0, 16'h0033, 0, "R3 pop2 push1");
    issue(0, 2, 0, 0, 0, 0, 16'h00a1, 16'h00b2, "R2 back-to-back push");
    issue(3, 0, 1, 0, 0, 0, 0, 0, "R3 peek three bytes");
    // R4 short words
    issue(0, 2, 0, 0, 1, 0, 16'h1234, 16'h5678, "R4 push words");
    issue(2, 0, 1, 0, 1, 0, 0, 0, "R4 peek words");
    issue(1, 1, 1, 0, 1, 0, 0, 16'hbeef, "R6 keep with result above");
    issue(3, 0, 1, 0, 1, 0, 0, 0, "R6 results above operands");
    issue(2, 1, 0, 0, 1, 0, 16'hcafe, 0, "R4 pop two words push one");
    idle(2);
    // R5 return stack
    issue(0, 1, 0, 1, 1, 0, 16'h4321, 0, "R5 push word to return");
    issue(1, 0, 1, 1, 1, 0, 0, 0, "R5 peek return word");
    issue(1, 1, 1, 1, 1, 0, 16'h4321, 0, "R4 short dup on return keeps order");
    issue(2, 0, 1, 1, 1, 0, 0, 0, "R5 check dup pair");
    // R7 transfers, both directions, push fields ignored
    issue(3, 2, 0, 0, 0, 1, 16'hffff, 16'heeee, "R7 stash byte to return");
    issue(0, 2, 0, 1, 1, 1, 16'hdddd, 16'hcccc, "R7 stash word back to data");
    issue(1, 0, 1, 1, 0, 0, 0, 0, "R7 peek return top");
    issue(2, 0, 1, 0, 1, 0, 0, 0, "R7 peek data words");
    idle(2);
    // R8 underflow
    issue(3, 0, 0, 1, 1, 0, 0, 0, "R8 underflow on return");
    issue(1, 0, 1, 0, 0, 0, 0, 0, "R8 sticky after underflow");
    idle(2);

    // R9 overflow boundary on data stack
    do_reset();
    for (int i = 0; i < 63; i++)
      issue(0, 2, 0, 0, 1, 0, 16'(i * 3), 16'(i * 7), "R9 fill");
    issue(0, 1, 0, 0, 1, 0, 16'h7e7f, 0, "R9 fill 254");
    issue(0, 1, 0, 0, 0, 0, 16'h00aa, 0, "R9 fill 255");
    issue(0, 1, 0, 0, 0, 0, 16'h00bb, 0, "R9 fill 256 legal");
    issue(0, 1, 0, 0, 0, 0, 16'h00cc, 0, "R9 overflow");
    issue(2, 0, 1, 0, 1, 0, 0, 0, "R9 top intact after overflow");
    issue(2, 1, 0, 0, 0, 0, 16'h0055, 0, "R10 pop2 push1 at full");
    idle(2);

    // R9 underflow precedence: empty data, full return
    do_reset();
    for (int i = 0; i < 64; i++)
      issue(0, 2, 0, 1, 1, 0, 16'(i), 16'(i + 100), "R9 fill return");
    issue(1, 0, 0, 0, 1, 1, 0, 0, "R9 underflow wins over overflow");
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule